// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block turns a peripheral clock of known frequency into the serial clock timing of an I2C master. Configuration gives the clock frequency in whole MHz, the wanted bus speed in kHz and a duty-cycle selector. When the generator is enabled it divides the clock frequency by a mode-dependent multiple of the bus speed, clamps the result, and flags configurations it cannot honour. Once the configuration is accepted it runs a free-running SCL drive waveform (low = pull the line down, high = release it) and pulses a tick at each phase change.

A bus speed of 100 kHz or less selects standard mode with a 1:1 duty. A faster speed selects fast mode, where the duty selector chooses between 2:1 and 16:9 (low:high). The division is done at run time by a serial restoring divider, so the quotient is ready a fixed number of cycles after enable. Configuration inputs are sampled only while the generator is disabled. Every enable restarts the waveform from a low phase. The high phase is timed from the moment the sampled SCL line is seen high, so a slow rise or a target stretching the clock lengthens it. `scl_in` is taken as already synchronised to `clk`.

Controller states: CT_OFF (sampling configuration), CT_LOAD (range check, divider start), CT_CALC (waiting for the quotient), CT_RUN (waveform running), CT_FAULT (configuration rejected). The controller moves CT_OFF→CT_LOAD on enable. CT_LOAD goes to CT_FAULT on a bad clock frequency and otherwise to CT_CALC. CT_CALC goes to CT_FAULT on divider overflow and otherwise to CT_RUN. Any state returns to CT_OFF when enable drops.

Phase states: PH_IDLE (released), PH_LOW (line held low), PH_WAIT_HIGH (released, waiting for the line to read high), PH_HIGH (counting the high time). The phase machine moves PH_IDLE→PH_LOW when the controller reaches CT_RUN. PH_LOW→PH_WAIT_HIGH and PH_HIGH→PH_LOW happen when the count expires. PH_WAIT_HIGH→PH_HIGH happens when `scl_in` reads 1. Every state returns to PH_IDLE when the controller leaves CT_RUN.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset `scl_en` is 1, and `phase_tick`, `cfg_ready`, `clk_range_err`, `div_ovf_err`, `fast_mode` and `div_out` are all 0.
- R2: A bus speed of 100 kHz or less selects standard mode. In standard mode `fast_mode` is 0 and `div_out` = floor(mhz·1000 / (2·khz)), clamped to at least 4. The low and high counts both equal `div_out`, `trise_out` = mhz + 1, and `duty_16_9` has no effect.
- R3: A bus speed above 100 kHz with `duty_16_9`=0 gives `fast_mode`=1 and `div_out` = floor(mhz·1000 / (3·khz)). The low count is 2·`div_out` and the high count is `div_out`.
- R4: A bus speed above 100 kHz with `duty_16_9`=1 gives `fast_mode`=1 and `div_out` = floor(mhz·1000 / (25·khz)). The low count is 16·`div_out` and the high count is 9·`div_out`.
- R5: In fast mode a quotient below 1 is clamped to `div_out`=1.
- R6: In fast mode `trise_out` = floor(mhz·300 / 1000) + 1.
- R7: A raw quotient above 4095 (including a bus speed of 0) raises `div_ovf_err`. It keeps `cfg_ready` at 0 and `scl_en` at 1, and no `phase_tick` occurs until enable is dropped.
- R8: A clock frequency outside 2..36 MHz raises `clk_range_err`, with `cfg_ready` 0, `scl_en` held at 1 and no ticks.
- R9: Each low phase lasts exactly the low count in cycles. After every enable the waveform begins with a full low phase.
- R10: The high count starts only after `scl_in` is seen high. A released interval lasts the high count + 1 detection cycle + the number of cycles `scl_in` is held low after release.
- R11: While running, `phase_tick` is a one-cycle pulse in the first cycle of each new phase (the cycle in which `scl_en` changes), except for the first low phase after enable.
- R12: Changing `pclk_mhz`, `bus_khz` or `duty_16_9` while enabled changes neither `div_out` nor the waveform timing. The new values take effect on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; configuration is sampled while low |
| pclk_mhz | input | MHZ_W (6) | Peripheral clock frequency in MHz |
| bus_khz | input | SPD_W (9) | Target bus speed in kHz |
| duty_16_9 | input | 1 | Fast-mode duty select: 0 = 2:1, 1 = 16:9 |
| scl_in | input | 1 | Sampled SCL line level |
| div_out | output | DIV_W (12) | Accepted divider value |
| fast_mode | output | 1 | 1 when fast mode is in use |
| trise_out | output | MHZ_W+1 (7) | Rise-time allowance count |
| cfg_ready | output | 1 | Configuration accepted, waveform running |
| clk_range_err | output | 1 | Clock frequency outside the allowed range |
| div_ovf_err | output | 1 | Divider result exceeds its field |
| scl_en | output | 1 | 1 = release SCL, 0 = drive SCL low |
| phase_tick | output | 1 | One-cycle pulse at each phase change |

## Verification
A wrong quotient or clamp in the divider shows on `div_out` as soon as `cfg_ready` rises, about twenty cycles after enable. It also shows in the measured low and high lengths within one SCL period. A phase machine stuck in the wait state, or one that counts before the line is high, shows as a released interval of the wrong length in the first full period. A controller that lets configuration through while running shows as a period change right after the inputs move. The checker also flags a tick with no edge on `scl_en` in the same cycle, and any fault flag that coincides with a running waveform.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [2:0] {
        CT_OFF,
        CT_LOAD,
        CT_CALC,
        CT_RUN,
        CT_FAULT
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT_HIGH,
        PH_HIGH
    } phase_state_t;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_SHIFT,
        DV_DONE
    } div_state_t;

    typedef enum logic [1:0] {
        DUTY_STD,
        DUTY_F2,
        DUTY_F169
    } duty_mode_t;

    // multiple of the bus speed that divides the clock for each duty mode
    function automatic logic [4:0] speed_factor(input duty_mode_t m);
        unique case (m)
            DUTY_STD:  speed_factor = 5'd2;
            DUTY_F2:   speed_factor = 5'd3;
            DUTY_F169: speed_factor = 5'd25;
            default:   speed_factor = 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/scl_div_unit.sv
module scl_div_unit
    import scl_timing_pkg::*;
#(
    parameter int NUM_W = 16,
    parameter int DEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CW = $clog2(NUM_W);

    div_state_t       st_q, st_n;
    logic [DEN_W-1:0] rem_q, den_q;
    logic [NUM_W-1:0] q_q;
    logic [CW-1:0]    cnt_q;

    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;
    logic [DEN_W-1:0] rem_n;

    always_comb begin
        shifted = {rem_q, q_q[NUM_W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
        rem_n   = fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
    end

    always_comb begin
        st_n = st_q;
        if (start) begin
            st_n = DV_SHIFT;
        end else begin
            unique case (st_q)
                DV_IDLE:  st_n = DV_IDLE;
                DV_SHIFT: if (cnt_q == '0) st_n = DV_DONE;
                DV_DONE:  st_n = DV_IDLE;
                default:  st_n = DV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DV_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
        end else if (start) begin
            rem_q <= '0;
            den_q <= denom;
            q_q   <= numer;
            cnt_q <= CW'(NUM_W - 1);
        end else if (st_q == DV_SHIFT) begin
            rem_q <= rem_n;
            q_q   <= {q_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (st_q == DV_DONE);
    assign quot = q_q;

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic             scl_in,
    output logic             scl_en,
    output logic             phase_tick
);
    phase_state_t     st_q, st_n;
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic             tick_n, tick_q;

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        tick_n = 1'b0;
        if (!run) begin
            st_n  = PH_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    st_n  = PH_LOW;
                    cnt_n = low_len - 1'b1;
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        st_n   = PH_WAIT_HIGH;
                        tick_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                PH_WAIT_HIGH: begin
                    if (scl_in) begin
                        st_n  = PH_HIGH;
                        cnt_n = high_len - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        st_n   = PH_LOW;
                        cnt_n  = low_len - 1'b1;
                        tick_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                default: st_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            tick_q <= tick_n;
        end
    end

    always_comb begin
        scl_en     = (st_q != PH_LOW);
        phase_tick = tick_q;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int MHZ_W        = 6,
    parameter int SPD_W        = 9,
    parameter int DIV_W        = 12,
    parameter int STD_MAX_KHZ  = 100,
    parameter int MHZ_MIN      = 2,
    parameter int MHZ_MAX      = 36,
    parameter int STD_MIN_DIV  = 4,
    parameter int FAST_MIN_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [MHZ_W-1:0] pclk_mhz,
    input  logic [SPD_W-1:0] bus_khz,
    input  logic             duty_16_9,
    input  logic             scl_in,
    output logic [DIV_W-1:0] div_out,
    output logic             fast_mode,
    output logic [MHZ_W:0]   trise_out,
    output logic             cfg_ready,
    output logic             clk_range_err,
    output logic             div_ovf_err,
    output logic             scl_en,
    output logic             phase_tick
);
    localparam int DIVD_W  = $clog2(((1 << MHZ_W) - 1) * 1000 + 1);
    localparam int DIVS_W  = SPD_W + 5;
    localparam int LEN_W   = DIV_W + 4;
    localparam int PROD_W  = MHZ_W + 9;
    localparam logic [DIVD_W-1:0] DIV_MAX = DIVD_W'((1 << DIV_W) - 1);

    ctl_state_t       st_q, st_n;
    logic [MHZ_W-1:0] cap_mhz;
    logic [SPD_W-1:0] cap_khz;
    logic             cap_duty;

    duty_mode_t       cap_mode;
    logic             cap_fast;
    logic             mhz_ok;
    logic [DIVD_W-1:0] dividend;
    logic [DIVS_W-1:0] divisor;
    logic             div_start;
    logic             div_done;
    logic [DIVD_W-1:0] quot;

    logic             ovf;
    logic [DIVD_W-1:0] min_div;
    logic [DIVD_W-1:0] clamped;
    logic [DIV_W-1:0] div_new;
    logic [PROD_W-1:0] mhz_x300;
    logic [MHZ_W:0]   trise_new;
    logic [LEN_W-1:0] low_new, high_new;

    logic [DIV_W-1:0] div_q;
    logic             fast_q;
    logic [MHZ_W:0]   trise_q;
    logic [LEN_W-1:0] low_len_q, high_len_q;
    logic             rng_err_q, ovf_err_q;

    // configuration decode from the captured values
    always_comb begin
        cap_fast = (int'(cap_khz) > STD_MAX_KHZ);
        if (!cap_fast)     cap_mode = DUTY_STD;
        else if (cap_duty) cap_mode = DUTY_F169;
        else               cap_mode = DUTY_F2;
        mhz_ok    = (int'(cap_mhz) >= MHZ_MIN) && (int'(cap_mhz) <= MHZ_MAX);
        dividend  = DIVD_W'(cap_mhz) * DIVD_W'(1000);
        divisor   = DIVS_W'(cap_khz) * DIVS_W'(speed_factor(cap_mode));
        div_start = (st_q == CT_LOAD) && mhz_ok;
    end

    scl_div_unit #(
        .NUM_W (DIVD_W),
        .DEN_W (DIVS_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .numer (dividend),
        .denom (divisor),
        .done  (div_done),
        .quot  (quot)
    );

    // post-processing of the quotient: clamp, overflow, phase lengths
    always_comb begin
        ovf      = (quot > DIV_MAX);
        min_div  = cap_fast ? DIVD_W'(FAST_MIN_DIV) : DIVD_W'(STD_MIN_DIV);
        clamped  = (quot < min_div) ? min_div : quot;
        div_new  = ovf ? '1 : clamped[DIV_W-1:0];
        mhz_x300 = PROD_W'(cap_mhz) * PROD_W'(300);
        if (cap_fast) trise_new = (MHZ_W+1)'(mhz_x300 / PROD_W'(1000)) + 1'b1;
        else          trise_new = {1'b0, cap_mhz} + 1'b1;
        unique case (cap_mode)
            DUTY_STD: begin
                low_new  = LEN_W'(div_new);
                high_new = LEN_W'(div_new);
            end
            DUTY_F2: begin
                low_new  = LEN_W'(div_new) << 1;
                high_new = LEN_W'(div_new);
            end
            DUTY_F169: begin
                low_new  = LEN_W'(div_new) << 4;
                high_new = (LEN_W'(div_new) << 3) + LEN_W'(div_new);
            end
            default: begin
                low_new  = LEN_W'(div_new);
                high_new = LEN_W'(div_new);
            end
        endcase
    end

    // controller next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            CT_OFF:   if (enable) st_n = CT_LOAD;
            CT_LOAD: begin
                if (!enable)     st_n = CT_OFF;
                else if (!mhz_ok) st_n = CT_FAULT;
                else             st_n = CT_CALC;
            end
            CT_CALC: begin
                if (!enable)       st_n = CT_OFF;
                else if (div_done) st_n = ovf ? CT_FAULT : CT_RUN;
            end
            CT_RUN:   if (!enable) st_n = CT_OFF;
            CT_FAULT: if (!enable) st_n = CT_OFF;
            default:  st_n = CT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CT_OFF;
        end else begin
            st_q <= st_n;
        end
    end

    // captured configuration and accepted results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mhz    <= '0;
            cap_khz    <= '0;
            cap_duty   <= 1'b0;
            div_q      <= '0;
            fast_q     <= 1'b0;
            trise_q    <= '0;
            low_len_q  <= '0;
            high_len_q <= '0;
            rng_err_q  <= 1'b0;
            ovf_err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                CT_OFF: begin
                    cap_mhz   <= pclk_mhz;
                    cap_khz   <= bus_khz;
                    cap_duty  <= duty_16_9;
                    rng_err_q <= 1'b0;
                    ovf_err_q <= 1'b0;
                end
                CT_LOAD: begin
                    if (enable && !mhz_ok) rng_err_q <= 1'b1;
                end
                CT_CALC: begin
                    if (enable && div_done) begin
                        div_q      <= div_new;
                        fast_q     <= cap_fast;
                        trise_q    <= trise_new;
                        low_len_q  <= low_new;
                        high_len_q <= high_new;
                        ovf_err_q  <= ovf;
                    end
                end
                CT_RUN, CT_FAULT: begin
                    if (!enable) begin
                        rng_err_q <= 1'b0;
                        ovf_err_q <= 1'b0;
                    end
                end
                default: begin
                    rng_err_q <= 1'b0;
                    ovf_err_q <= 1'b0;
                end
            endcase
        end
    end

    scl_phase_fsm #(
        .LEN_W (LEN_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_q == CT_RUN),
        .low_len    (low_len_q),
        .high_len   (high_len_q),
        .scl_in     (scl_in),
        .scl_en     (scl_en),
        .phase_tick (phase_tick)
    );

    always_comb begin
        div_out       = div_q;
        fast_mode     = fast_q;
        trise_out     = trise_q;
        cfg_ready     = (st_q == CT_RUN);
        clk_range_err = rng_err_q;
        div_ovf_err   = ovf_err_q;
    end

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ready,
    input logic             clk_range_err,
    input logic             div_ovf_err,
    input logic             scl_en,
    input logic             phase_tick,
    input logic             fast_mode,
    input logic [DIV_W-1:0] div_out
);
    assert_std_min_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && !fast_mode) |-> (div_out >= DIV_W'(4)));

    assert_fast_min_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && fast_mode) |-> (div_out != '0));

    assert_ovf_blocks_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_ovf_err |-> (!cfg_ready && scl_en && !phase_tick));

    assert_range_blocks_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_range_err |-> (!cfg_ready && scl_en && !phase_tick));

    assert_tick_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> (scl_en != $past(scl_en)));

    assert_div_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && $past(cfg_ready)) |-> $stable(div_out));

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ready     (cfg_ready),
    .clk_range_err (clk_range_err),
    .div_ovf_err   (div_ovf_err),
    .scl_en        (scl_en),
    .phase_tick    (phase_tick),
    .fast_mode     (fast_mode),
    .div_out       (div_out)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [5:0]  pclk_mhz = '0;
    logic [8:0]  bus_khz = '0;
    logic        duty_16_9 = 1'b0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic [11:0] div_out;
    logic        fast_mode;
    logic [6:0]  trise_out;
    logic        cfg_ready, clk_range_err, div_ovf_err, scl_en, phase_tick;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    assign scl_in = scl_en & ~hold_low;

    scl_timing_gen u_dut (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .pclk_mhz (pclk_mhz), .bus_khz (bus_khz), .duty_16_9 (duty_16_9),
        .scl_in (scl_in), .div_out (div_out), .fast_mode (fast_mode),
        .trise_out (trise_out), .cfg_ready (cfg_ready),
        .clk_range_err (clk_range_err), .div_ovf_err (div_ovf_err),
        .scl_en (scl_en), .phase_tick (phase_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_div(input int mhz, input int khz, input bit d169);
        int k, q;
        if (khz <= 100) k = 2; else if (d169) k = 25; else k = 3;
        q = (khz == 0) ? 65535 : (mhz * 1000) / (k * khz);
        if (khz <= 100 && q < 4) q = 4;
        if (khz > 100 && q < 1) q = 1;
        return q;
    endfunction

    function automatic int exp_trise(input int mhz, input int khz);
        if (khz <= 100) return mhz + 1;
        return (mhz * 300) / 1000 + 1;
    endfunction

    function automatic int exp_low(input int d, input int khz, input bit d169);
        if (khz <= 100) return d;
        return d169 ? 16 * d : 2 * d;
    endfunction

    function automatic int exp_high(input int d, input int khz, input bit d169);
        if (khz <= 100) return d;
        return d169 ? 9 * d : d;
    endfunction

    task automatic configure(input int mhz, input int khz, input bit d169);
        @(negedge clk);
        enable = 1'b0;
        pclk_mhz = 6'(mhz);
        bus_khz = 9'(khz);
        duty_16_9 = d169;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cfg_ready || clk_range_err || div_ovf_err) break;
        end
    endtask

    // waits for a falling scl_en, then measures low, high and the next low
    task automatic measure(input int lo_exp, input int hi_exp, input string tag);
        int lo = 0, hi = 0, lo2 = 0;
        while (scl_en !== 1'b1) @(negedge clk);
        while (scl_en === 1'b1) @(negedge clk);
        while (scl_en === 1'b0) begin lo++; @(negedge clk); end
        check(phase_tick === 1'b1, {tag, " R11 tick at release"}, int'(phase_tick), 1);
        while (scl_en === 1'b1) begin hi++; @(negedge clk); end
        check(phase_tick === 1'b1, {tag, " R11 tick at low start"}, int'(phase_tick), 1);
        while (scl_en === 1'b0) begin lo2++; @(negedge clk); end
        check(lo == lo_exp, {tag, " R9 low length"}, lo, lo_exp);
        check(hi == hi_exp + 1, {tag, " R10 released length"}, hi, hi_exp + 1);
        check(lo2 == lo_exp, {tag, " R9 second low length"}, lo2, lo_exp);
    endtask

    task automatic run_good(input int mhz, input int khz, input bit d169, input string tag);
        int d;
        d = exp_div(mhz, khz, d169);
        configure(mhz, khz, d169);
        check(cfg_ready === 1'b1, {tag, " ready"}, int'(cfg_ready), 1);
        check(int'(div_out) == d, {tag, " divider"}, int'(div_out), d);
        check(fast_mode === (khz > 100), {tag, " fast flag"}, int'(fast_mode), int'(khz > 100));
        check(int'(trise_out) == exp_trise(mhz, khz), {tag, " rise count"},
              int'(trise_out), exp_trise(mhz, khz));
        measure(exp_low(d, khz, d169), exp_high(d, khz, d169), tag);
    endtask

    task automatic test_reset();
        check(scl_en === 1'b1 && phase_tick === 1'b0, "R1 idle line", int'(scl_en), 1);
        check(cfg_ready === 1'b0 && clk_range_err === 1'b0 && div_ovf_err === 1'b0,
              "R1 flags clear", int'(cfg_ready), 0);
        check(div_out === 12'd0 && fast_mode === 1'b0, "R1 divider zero", int'(div_out), 0);
    endtask

    task automatic test_fault(input int mhz, input int khz, input bit want_rng, input string tag);
        int ticks = 0, lows = 0;
        configure(mhz, khz, 1'b0);
        check(clk_range_err === want_rng, {tag, " range flag"}, int'(clk_range_err), int'(want_rng));
        check(div_ovf_err === !want_rng, {tag, " overflow flag"}, int'(div_ovf_err), int'(!want_rng));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (phase_tick) ticks++;
            if (!scl_en || cfg_ready) lows++;
        end
        check(ticks == 0 && lows == 0, {tag, " line stays released"}, ticks + lows, 0);
    endtask

    task automatic test_stretch();
        int d, hi;
        d = exp_div(8, 100, 1'b0);
        configure(8, 100, 1'b0);
        while (scl_en !== 1'b0) @(negedge clk);
        hold_low = 1'b1;
        while (scl_en !== 1'b1) @(negedge clk);
        hi = 1;
        repeat (20) begin @(negedge clk); hi++; end
        hold_low = 1'b0;
        @(negedge clk);
        while (scl_en === 1'b1) begin hi++; @(negedge clk); end
        check(hi == d + 21, "R10 stretched high", hi, d + 21);
    endtask

    task automatic test_live_change();
        configure(8, 100, 1'b0);
        @(negedge clk);
        pclk_mhz = 6'd36;
        bus_khz = 9'd400;
        duty_16_9 = 1'b1;
        measure(40, 40, "R12 inputs moved while running");
        check(div_out == 12'd40, "R12 divider held", int'(div_out), 40);
        run_good(36, 400, 1'b1, "R12 applied after re-enable");
    endtask

    task automatic test_restart();
        configure(8, 400, 1'b0);
        while (scl_en !== 1'b0) @(negedge clk);
        while (scl_en !== 1'b1) @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        measure(12, 6, "R9 restart from low");
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_good(8, 100, 1'b0, "R2 standard 8MHz/100k");
        run_good(8, 100, 1'b1, "R2 duty select ignored");
        run_good(8, 101, 1'b0, "R3 fast boundary 101k");
        run_good(8, 400, 1'b0, "R3 fast 2:1");
        run_good(36, 400, 1'b1, "R4 fast 16:9");
        run_good(2, 400, 1'b1, "R5 clamp to one R6");
        run_good(20, 350, 1'b0, "R6 rise count 20MHz");
        test_fault(36, 1, 1'b0, "R7 overflow");
        test_fault(36, 0, 1'b0, "R7 zero speed");
        test_fault(1, 100, 1'b1, "R8 below range");
        test_fault(37, 100, 1'b1, "R8 above range");
        test_stretch();
        test_live_change();
        test_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule